// File: doc/BRIEF.md
# Program Counter and Instruction Sequencer

This block produces the fetch address for a small pipelined controller and paces its instruction cycles. A free-running phase counter splits every instruction cycle into four non-overlapping system-clock phases, and the fetch address changes only on the edge that closes the fourth phase. At that edge the block picks the next address from one of these sources: sequential increment, a taken skip, an immediate jump or call target, a return from a two-entry stack, a rewrite of the low address byte, and fixed vectors for reset, the external interrupt and the timer overflow.

Fetch and execute overlap, so the word fetched while a transfer executes is stale. The block raises `flush` for the whole following instruction cycle. This tells the execute stage to run a dummy cycle in place of the prefetched word. Instruction requests presented during that dummy cycle are dropped. Interrupts are still taken during it.

The decoder holds its requests steady through an instruction cycle. The block samples them only at the closing edge of the cycle.

Top module: `pc_sequencer`

## Requirements
- R1: `phase` is one-hot and advances 0001→0010→0100→1000→0001 on every clock, with bit 0 (first phase) set in the cycle after reset.
- R2: Synchronous active-low reset drives `rom_addr` to 0, `flush` to 0 and `phase` to 0001, and discards any pending interrupt.
- R3: Without any request, `rom_addr` increases by one at each instruction-cycle boundary and stays unchanged in the other three phases. Crossing from 0x0FF to 0x100 needs no special handling.
- R4: A taken skip (`op_skip`) moves `rom_addr` to the next address and raises `flush` for one instruction cycle, so the prefetched word is discarded.
- R5: A low-byte write (`op_pcl_wr`) replaces `rom_addr[7:0]` with `pcl_data` and keeps the upper bits, then raises `flush`.
- R6: A jump (`op_jump`) loads `target` into `rom_addr` and raises `flush`.
- R7: A call (`op_call`) pushes the current `rom_addr`, loads `target` and raises `flush`. A return (`op_ret`) loads the top stack entry and raises `flush`.
- R8: The stack holds two entries and returns them newest first. A third push discards the oldest entry. A pop keeps the bottom entry, so further returns reuse it.
- R9: A high-to-low transition on `ext_int_n` makes the next boundary push the current address, load 0x004 and raise `flush`. A low level that persists and a rising edge trigger nothing.
- R10: A one-clock `tmr_ovf` pulse makes a boundary load 0x008 in the same way. When both interrupts are pending, 0x004 is taken first and 0x008 at the following boundary.
- R11: A pending interrupt overrides an instruction request presented at the same boundary. That request is lost.
- R12: `flush` stays high for exactly one instruction cycle after a transfer, unless another transfer follows. Instruction requests presented during that dummy cycle are ignored and the address simply increments.
- R13: When several instruction requests coincide, return beats call, call beats jump, jump beats low-byte write, and low-byte write beats skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_skip | input | 1 | Conditional skip taken |
| op_pcl_wr | input | 1 | Write of the low address byte |
| pcl_data | input | 8 | Data for the low-byte write |
| op_jump | input | 1 | Jump to `target` |
| op_call | input | 1 | Call to `target` |
| op_ret | input | 1 | Return from subroutine |
| target | input | PC_W | Immediate jump or call address |
| ext_int_n | input | 1 | External interrupt pin, falling-edge triggered |
| tmr_ovf | input | 1 | Timer overflow pulse |
| rom_addr | output | PC_W | Current fetch address |
| phase | output | 4 | One-hot phase of the instruction cycle |
| flush | output | 1 | Current cycle executes a dummy instead of the prefetched word |

## Verification
Every fault in this block shows at the ports within one instruction cycle. A wrong source choice or priority shows as a wrong `rom_addr` in the first phase after the boundary. A wrong `flush` shows as a dummy cycle that is missing or extra, or as a request in a dummy cycle that still moves the address. Stack faults stay hidden until the next return, so the bench ends each call chain with returns and checks the address each one produces. An interrupt latch that is lost or stuck shows at the next boundary, either as a missing vector or as a second one.

// File: rtl/pcseq_pkg.sv
`timescale 1ns/1ps
// Shared types for the program-counter sequencer.
// Assumes: one address source is chosen per instruction-cycle boundary.
package pcseq_pkg;
    typedef enum logic [2:0] {
        SRC_INC,
        SRC_SKIP,
        SRC_PCL,
        SRC_JMP,
        SRC_CALL,
        SRC_RET,
        SRC_EXT,
        SRC_TMR
    } src_e;
endpackage

// File: rtl/pcseq_phase.sv
`timescale 1ns/1ps
// Phase generator: divides the system clock into PHASES one-hot phases.
// Assumes: the last phase marks the instruction-cycle boundary edge.
module pcseq_phase #(
    parameter int PHASES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PHASES-1:0] phase,
    output logic              last
);
    localparam int CW = (PHASES > 1) ? $clog2(PHASES) : 1;

    logic [CW-1:0] cnt_q;

    // Purpose: wrap the phase counter at the end of each instruction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (cnt_q == CW'(PHASES - 1))   cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
    end

    for (genvar i = 0; i < PHASES; i++) begin : g_dec
        assign phase[i] = (cnt_q == CW'(i));
    end

    assign last = phase[PHASES-1];

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);                                   // R1
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        phase[PHASES-1] |=> phase[0]);                             // R1
endmodule

// File: rtl/pcseq_stack.sv
`timescale 1ns/1ps
// Return-address stack: a push shifts the entries down and a pop shifts them up.
// Assumes: push and pop are never requested together; an overflow drops the oldest
// entry, and an underflow keeps returning the bottom entry.
module pcseq_stack #(
    parameter int W     = 10,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);
    logic [W-1:0] ent_q [DEPTH];

    // Purpose: shift the entries on push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
        end else if (push) begin
            ent_q[0] <= din;
            for (int k = 1; k < DEPTH; k++) ent_q[k] <= ent_q[k-1];
        end else if (pop) begin
            for (int k = 0; k < DEPTH - 1; k++) ent_q[k] <= ent_q[k+1];
        end
    end

    assign top = ent_q[0];

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> top == $past(din));                               // R8
    AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));                                           // R7
endmodule

// File: rtl/pcseq_irq.sv
`timescale 1ns/1ps
// Interrupt latch: detects a falling edge on the external pin and catches timer
// pulses; each request stays pending until its acknowledge.
// Assumes: a new event that arrives on the acknowledge edge stays pending.
module pcseq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_n,
    input  logic tmr_ovf,
    input  logic ack_ext,
    input  logic ack_tmr,
    output logic ext_pend,
    output logic tmr_pend
);
    logic ext_q;
    logic fall;

    assign fall = ext_q & ~ext_n;

    // Purpose: track the pin level and hold the pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q    <= 1'b1;
            ext_pend <= 1'b0;
            tmr_pend <= 1'b0;
        end else begin
            ext_q    <= ext_n;
            ext_pend <= (ext_pend & ~ack_ext) | fall;
            tmr_pend <= (tmr_pend & ~ack_tmr) | tmr_ovf;
        end
    end

    AST_EXT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> ext_pend);                                        // R9
    AST_TMR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> tmr_pend);                                     // R10
endmodule

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
// Program-counter sequencer: selects the next fetch address at each
// instruction-cycle boundary and flags the dummy cycle after a transfer.
// Assumes: PC_W > 8; the decoder holds its requests for a whole instruction cycle.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int              PC_W    = 10,
    parameter int              DEPTH   = 2,
    parameter logic [PC_W-1:0] VEC_EXT = PC_W'(4),
    parameter logic [PC_W-1:0] VEC_TMR = PC_W'(8)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_skip,
    input  logic            op_pcl_wr,
    input  logic [7:0]      pcl_data,
    input  logic            op_jump,
    input  logic            op_call,
    input  logic            op_ret,
    input  logic [PC_W-1:0] target,
    input  logic            ext_int_n,
    input  logic            tmr_ovf,
    output logic [PC_W-1:0] rom_addr,
    output logic [3:0]      phase,
    output logic            flush
);
    localparam int NPH = 4;

    logic            boundary;
    logic            ext_pend, tmr_pend;
    logic            push, pop;
    logic [PC_W-1:0] stk_top;
    logic [PC_W-1:0] pc_q, pc_inc, pc_nxt;
    logic            flush_q;
    src_e            src;

    pcseq_phase #(.PHASES(NPH)) i_phase (
        .clk(clk), .rst_n(rst_n), .phase(phase), .last(boundary)
    );

    pcseq_irq i_irq (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_int_n), .tmr_ovf(tmr_ovf),
        .ack_ext(boundary && src == SRC_EXT),
        .ack_tmr(boundary && src == SRC_TMR),
        .ext_pend(ext_pend), .tmr_pend(tmr_pend)
    );

    pcseq_stack #(.W(PC_W), .DEPTH(DEPTH)) i_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .din(pc_q), .top(stk_top)
    );

    assign pc_inc = pc_q + PC_W'(1);

    // Purpose: choose the address source; interrupts first, dummy cycles ignore requests.
    always_comb begin
        if (ext_pend)       src = SRC_EXT;
        else if (tmr_pend)  src = SRC_TMR;
        else if (flush_q)   src = SRC_INC;
        else if (op_ret)    src = SRC_RET;
        else if (op_call)   src = SRC_CALL;
        else if (op_jump)   src = SRC_JMP;
        else if (op_pcl_wr) src = SRC_PCL;
        else if (op_skip)   src = SRC_SKIP;
        else                src = SRC_INC;
    end

    // Purpose: form the next fetch address for the chosen source.
    always_comb begin
        case (src)
            SRC_EXT:           pc_nxt = VEC_EXT;
            SRC_TMR:           pc_nxt = VEC_TMR;
            SRC_RET:           pc_nxt = stk_top;
            SRC_CALL, SRC_JMP: pc_nxt = target;
            SRC_PCL:           pc_nxt = {pc_q[PC_W-1:8], pcl_data};
            default:           pc_nxt = pc_inc;
        endcase
    end

    assign push = boundary && (src == SRC_CALL || src == SRC_EXT || src == SRC_TMR);
    assign pop  = boundary && (src == SRC_RET);

    // Purpose: update the address and the dummy-cycle flag at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            flush_q <= 1'b0;
        end else if (boundary) begin
            pc_q    <= pc_nxt;
            flush_q <= (src != SRC_INC);
        end
    end

    assign rom_addr = pc_q;
    assign flush    = flush_q;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(rom_addr));                          // R3
    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(flush));                             // R12
    AST_IDLE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && !ext_pend && !tmr_pend && !flush && !op_ret && !op_call
        && !op_jump && !op_pcl_wr && !op_skip
        |=> rom_addr == PC_W'($past(rom_addr) + 1'b1) && !flush);  // R3
    AST_DUMMY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && flush && !ext_pend && !tmr_pend
        |=> rom_addr == PC_W'($past(rom_addr) + 1'b1) && !flush);  // R12
    AST_EXT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && ext_pend |=> rom_addr == VEC_EXT && flush);    // R11
    AST_TMR_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && tmr_pend && !ext_pend |=> rom_addr == VEC_TMR && flush); // R10
endmodule

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_skip = 0, op_pcl_wr = 0, op_jump = 0, op_call = 0, op_ret = 0;
    logic [7:0] pcl_data = '0;
    logic [9:0] target = '0;
    logic       ext_int_n = 1'b1, tmr_ovf = 1'b0;
    logic [9:0] rom_addr;
    logic [3:0] phase;
    logic       flush;

    int n_run = 0, n_fail = 0;
    logic done = 1'b0;
    logic prev_flush = 1'b0;

    always #10 clk = ~clk;

    pc_sequencer i_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .op_skip(op_skip), .op_pcl_wr(op_pcl_wr),
        .pcl_data(pcl_data), .op_jump(op_jump), .op_call(op_call), .op_ret(op_ret),
        .target(target), .ext_int_n(ext_int_n), .tmr_ovf(tmr_ovf),
        .rom_addr(rom_addr), .phase(phase), .flush(flush)
    );

    // Request bits: {ret, call, jump, pcl_wr, skip}; then data, target, expected address, expected flush.
    localparam int NV = 27;
    localparam logic [33:0] VEC [NV] = '{
        {5'b00000, 8'h00, 10'h000, 10'h001, 1'b0},
        {5'b00000, 8'h00, 10'h000, 10'h002, 1'b0},
        {5'b00001, 8'h00, 10'h000, 10'h003, 1'b1},
        {5'b00100, 8'h00, 10'h155, 10'h004, 1'b0},
        {5'b00100, 8'h00, 10'h155, 10'h155, 1'b1},
        {5'b00000, 8'h00, 10'h000, 10'h156, 1'b0},
        {5'b00010, 8'h20, 10'h000, 10'h120, 1'b1},
        {5'b00000, 8'h00, 10'h000, 10'h121, 1'b0},
        {5'b01000, 8'h00, 10'h300, 10'h300, 1'b1},
        {5'b00000, 8'h00, 10'h000, 10'h301, 1'b0},
        {5'b01000, 8'h00, 10'h080, 10'h080, 1'b1},
        {5'b00000, 8'h00, 10'h000, 10'h081, 1'b0},
        {5'b10000, 8'h00, 10'h000, 10'h301, 1'b1},
        {5'b00000, 8'h00, 10'h000, 10'h302, 1'b0},
        {5'b10000, 8'h00, 10'h000, 10'h121, 1'b1},
        {5'b00000, 8'h00, 10'h000, 10'h122, 1'b0},
        {5'b11111, 8'h55, 10'h2AA, 10'h121, 1'b1},
        {5'b00000, 8'h00, 10'h000, 10'h122, 1'b0},
        {5'b01111, 8'h55, 10'h2AA, 10'h2AA, 1'b1},
        {5'b00000, 8'h00, 10'h000, 10'h2AB, 1'b0},
        {5'b00111, 8'h55, 10'h010, 10'h010, 1'b1},
        {5'b00000, 8'h00, 10'h000, 10'h011, 1'b0},
        {5'b00011, 8'hFE, 10'h000, 10'h0FE, 1'b1},
        {5'b00000, 8'h00, 10'h000, 10'h0FF, 1'b0},
        {5'b00000, 8'h00, 10'h000, 10'h100, 1'b0},
        {5'b10000, 8'h00, 10'h000, 10'h122, 1'b1},
        {5'b00000, 8'h00, 10'h000, 10'h123, 1'b0}
    };

    task automatic check(input string tag, input logic [9:0] exp_a, input logic exp_f);
        n_run++;
        if (rom_addr !== exp_a || flush !== exp_f) begin
            n_fail++;
            $display("FAIL %s: addr=%h flush=%b expected addr=%h flush=%b",
                     tag, rom_addr, flush, exp_a, exp_f);
        end
    endtask

    // Runs one instruction cycle from the first phase; ends in the next first phase.
    task automatic instr(input logic [4:0] req, input logic [7:0] d, input logic [9:0] t,
                         input logic efall, input logic tpulse);
        prev_flush = flush;
        {op_ret, op_call, op_jump, op_pcl_wr, op_skip} = req;
        pcl_data = d;
        target   = t;
        if (efall) ext_int_n = 1'b0;
        tmr_ovf = tpulse;
        @(negedge clk);
        tmr_ovf = 1'b0;
        repeat (3) @(negedge clk);
        {op_ret, op_call, op_jump, op_pcl_wr, op_skip} = '0;
    endtask

    function automatic string tag_of(input logic [4:0] req, input logic pf);
        if (pf && req != 0)        return "R12";
        if ($countones(req) > 1)   return "R13";
        if (req[4] || req[3])      return "R7";
        if (req[2])                return "R6";
        if (req[1])                return "R5";
        if (req[0])                return "R4";
        return "R3";
    endfunction

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        n_run++;
        if (rom_addr !== 10'h000 || flush !== 1'b0 || phase !== 4'b0001) begin
            n_fail++;
            $display("FAIL R2: addr=%h flush=%b phase=%b expected 000 0 0001", rom_addr, flush, phase);
        end
        rst_n = 1'b1;
        // R1: phase rotation
        for (int k = 0; k < 8; k++) begin
            logic [3:0] exp_ph;
            exp_ph = 4'b0001 << (k % 4);
            n_run++;
            if (phase !== exp_ph) begin
                n_fail++;
                $display("FAIL R1: phase=%b expected %b", phase, exp_ph);
            end
            @(negedge clk);
        end
        // After 8 clocks two boundaries passed: address 2. Re-align with a reset.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [33:0] e;
            string tg;
            e = VEC[v];
            tg = tag_of(e[33:29], flush);
            instr(e[33:29], e[28:21], e[20:11], 1'b0, 1'b0);
            check(tg, e[10:1], e[0]);
        end

        // R8: overflow of the two-entry stack
        instr(5'b01000, 8'h00, 10'h040, 1'b0, 1'b0); check("R7", 10'h040, 1'b1);
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R3", 10'h041, 1'b0);
        instr(5'b01000, 8'h00, 10'h050, 1'b0, 1'b0); check("R7", 10'h050, 1'b1);
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R3", 10'h051, 1'b0);
        instr(5'b01000, 8'h00, 10'h060, 1'b0, 1'b0); check("R8", 10'h060, 1'b1);
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R3", 10'h061, 1'b0);
        instr(5'b10000, 8'h00, 10'h000, 1'b0, 1'b0); check("R8", 10'h051, 1'b1);
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R3", 10'h052, 1'b0);
        instr(5'b10000, 8'h00, 10'h000, 1'b0, 1'b0); check("R8", 10'h041, 1'b1);
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R3", 10'h042, 1'b0);
        instr(5'b10000, 8'h00, 10'h000, 1'b0, 1'b0); check("R8", 10'h041, 1'b1);
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R3", 10'h042, 1'b0);

        // R9, R11: external interrupt beats a jump; a persistent low level does not retrigger
        instr(5'b00100, 8'h00, 10'h3F0, 1'b1, 1'b0); check("R11", 10'h004, 1'b1);
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R9", 10'h005, 1'b0);
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R9", 10'h006, 1'b0);
        ext_int_n = 1'b1;
        instr(5'b10000, 8'h00, 10'h000, 1'b0, 1'b0); check("R11", 10'h042, 1'b1);
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R9", 10'h043, 1'b0);

        // R10: timer overflow alone
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b1); check("R10", 10'h008, 1'b1);
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R10", 10'h009, 1'b0);
        instr(5'b10000, 8'h00, 10'h000, 1'b0, 1'b0); check("R7", 10'h043, 1'b1);
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R3", 10'h044, 1'b0);

        // R10: both pending, external first, timer at the next boundary
        instr(5'b00000, 8'h00, 10'h000, 1'b1, 1'b1); check("R10", 10'h004, 1'b1);
        ext_int_n = 1'b1;
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R10", 10'h008, 1'b1);
        instr(5'b10000, 8'h00, 10'h000, 1'b0, 1'b0); check("R12", 10'h009, 1'b0);
        instr(5'b10000, 8'h00, 10'h000, 1'b0, 1'b0); check("R8", 10'h004, 1'b1);
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R3", 10'h005, 1'b0);
        instr(5'b10000, 8'h00, 10'h000, 1'b0, 1'b0); check("R8", 10'h044, 1'b1);

        // R2: reset during operation clears a pending interrupt
        ext_int_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        n_run++;
        if (rom_addr !== 10'h000 || flush !== 1'b0 || phase !== 4'b0001) begin
            n_fail++;
            $display("FAIL R2: addr=%h flush=%b phase=%b expected 000 0 0001", rom_addr, flush, phase);
        end
        ext_int_n = 1'b1;
        rst_n = 1'b1;
        instr(5'b00000, 8'h00, 10'h000, 1'b0, 1'b0); check("R2", 10'h001, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule